// File: doc/BRIEF.md
# Functional Broadside Test Controller

This block sequences built-in two-pattern delay tests on a small scan-based sequential circuit under test (CUT). After a hardware reset puts the CUT in a known reachable state, an external sequencer presents one functional input vector per cycle. The CUT keeps running in functional mode, so every state it passes through is reachable. Any of those states can therefore start a test. No test states are stored and no multiplexer chooses between stored tests.

A fixed selection gate looks at each incoming vector. The gate is an AND over a parameterised set of vector bits, by default bits 0 and 3. When the gate fires, the controller starts a test. The current vector is the slow launch vector, and the next valid vector is applied with the fast clock selected. In that fast cycle the CUT output is folded into an 8-bit multiple-input signature register (MISR). In the cycle after it, the CUT state that the fast clock produced is folded in as well. Tests never overlap.

A saturating counter reports how many tests were applied. A done flag marks the end of the sequence. The controller has four named states:
- FUNC: functional run.
- FAST: waiting to apply the at-speed vector.
- CAPT: capture of the resulting state.
- DONE: end of the sequence, left only by reset.

Its transitions are:
- FUNC→FAST on a launch.
- FUNC→DONE on a last vector with no launch.
- FAST→CAPT on the fast cycle.
- FAST→FAST while stalled.
- CAPT→FAST on a back-to-back launch.
- CAPT→DONE when the fast vector was the last one, or when a last vector arrives.
- CAPT→FUNC otherwise.

Top module: `fbt_ctrl`

## Requirements
- R1: While `rst_n` is low and at the first cycle after its release, `misr_sig` is 0, `test_cnt` is 0, and `seq_done`, `fast_clk_sel` and `test_launch` are 0.
- R2: `test_launch` is high in a cycle exactly when all of the following hold: `sel_en` is 1, `seq_valid` is 1, `seq_last` is 0, `vec_in[0]` and `vec_in[3]` are both 1 (default mask 4'b1001), and the controller is in FUNC, or in CAPT with the previous fast vector not being the last.
- R3: After a launch, `fast_clk_sel` is high in the next cycle that has `seq_valid` = 1, and only in that one cycle.
- R4: A gate firing in the cycle that applies the fast vector is ignored. A new test may start in the following cycle, so two launches are at least two cycles apart.
- R5: The MISR updates only in the fast cycle and in the cycle after it, holding otherwise. Each update computes next = {sig[6:0], sig[7]^sig[5]^sig[4]^sig[3]} XOR data. In the fast cycle, data is `cut_out` zero-extended. In the cycle after it, data is `cut_state` zero-extended.
- R6: `test_cnt` increases by one after each fast cycle and saturates at 255.
- R7: A valid vector with `seq_last` = 1 sends the controller to DONE. If that vector is the fast vector, DONE follows the capture cycle. A gate firing on the last vector is ignored. In DONE, `seq_done` is 1 and no input changes anything until reset.
- R8: With `sel_en` = 0 no test is launched, `fast_clk_sel` stays 0 and the MISR holds.
- R9: Cycles with `seq_valid` = 0 after a launch keep `fast_clk_sel` low and delay the fast cycle until a valid vector arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, brings block to its initial state |
| sel_en | input | 1 | Enables the test selection gate |
| seq_valid | input | 1 | A vector is present on `vec_in` this cycle |
| seq_last | input | 1 | The present vector is the final one of the sequence |
| vec_in | input | PI_W (4) | Functional input vector a(u) from the sequencer |
| cut_out | input | PO_W (1) | CUT output vector |
| cut_state | input | ST_W (3) | CUT state bus |
| test_launch | output | 1 | This cycle is the slow launch cycle of a test |
| fast_clk_sel | output | 1 | Apply this cycle's vector with the fast clock |
| misr_sig | output | MISR_W (8) | Signature register contents |
| test_cnt | output | CNT_W (8) | Number of tests applied, saturating |
| seq_done | output | 1 | Sequence finished |

## Verification
`test_launch` and `fast_clk_sel` are combinational in the cycle of the vector that causes them. The bench therefore checks them one nanosecond after driving inputs at the falling edge, before the next rising edge. `misr_sig`, `test_cnt` and `seq_done` change at the rising edge that ends that cycle, and the bench checks them one nanosecond after that edge. A cycle-level model in the bench steps once per cycle and predicts both groups. The stimulus includes the following:
- A full sweep of all sixteen vectors.
- Pseudo-random vectors with stalls.
- Back-to-back firings.
- Last-vector cases.
- A run long enough to saturate the counter.

// File: rtl/fbt_pkg.sv
package fbt_pkg;
    typedef enum logic [1:0] {
        ST_FUNC = 2'd0,
        ST_FAST = 2'd1,
        ST_CAPT = 2'd2,
        ST_DONE = 2'd3
    } fbt_state_e;
endpackage

// File: rtl/fbt_sel_gate.sv
module fbt_sel_gate #(
    parameter int              PI_W     = 4,
    parameter logic [PI_W-1:0] SEL_MASK = PI_W'(9)
) (
    input  logic            sel_en,
    input  logic            seq_valid,
    input  logic            seq_last,
    input  logic [PI_W-1:0] vec_in,
    output logic            sel_fire
);
    // AND of the masked bits; a last vector has no successor, so it never fires
    assign sel_fire = sel_en && seq_valid && !seq_last && (&(vec_in | ~SEL_MASK));
endmodule

// File: rtl/fbt_misr.sv
module fbt_misr #(
    parameter int                MISR_W   = 8,
    parameter logic [MISR_W-1:0] TAP_MASK = MISR_W'(8'hB8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [MISR_W-1:0] cap_data,
    output logic [MISR_W-1:0] signature
);
    logic fb;
    assign fb = ^(signature & TAP_MASK);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            signature <= '0;
        else if (cap_en)
            signature <= {signature[MISR_W-2:0], fb} ^ cap_data;
    end

    AST_MISR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> $stable(signature)); // R5
endmodule

// File: rtl/fbt_seq_fsm.sv
module fbt_seq_fsm
    import fbt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seq_valid,
    input  logic             seq_last,
    input  logic             sel_fire,
    output logic             test_launch,
    output logic             fast_clk_sel,
    output logic             misr_en,
    output logic             misr_take_state,
    output logic             seq_done,
    output logic [CNT_W-1:0] test_cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    fbt_state_e st_q, st_d;
    logic       last_q, last_d;

    // state register and test counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_FUNC;
            last_q   <= 1'b0;
            test_cnt <= '0;
        end else begin
            st_q   <= st_d;
            last_q <= last_d;
            if (fast_clk_sel && test_cnt != CNT_MAX)
                test_cnt <= test_cnt + CNT_W'(1);
        end
    end

    // next state
    always_comb begin
        st_d   = st_q;
        last_d = last_q;
        unique case (st_q)
            ST_FUNC: begin
                if (test_launch)                st_d = ST_FAST;
                else if (seq_valid && seq_last) st_d = ST_DONE;
            end
            ST_FAST: begin
                if (seq_valid) begin
                    st_d   = ST_CAPT;
                    last_d = seq_last;
                end
            end
            ST_CAPT: begin
                if (last_q)                     st_d = ST_DONE;
                else if (test_launch)           st_d = ST_FAST;
                else if (seq_valid && seq_last) st_d = ST_DONE;
                else                            st_d = ST_FUNC;
            end
            ST_DONE: st_d = ST_DONE;
        endcase
    end

    // outputs
    always_comb begin
        test_launch     = 1'b0;
        fast_clk_sel    = 1'b0;
        misr_en         = 1'b0;
        misr_take_state = 1'b0;
        seq_done        = 1'b0;
        unique case (st_q)
            ST_FUNC: test_launch = sel_fire;
            ST_FAST: begin
                fast_clk_sel = seq_valid;
                misr_en      = seq_valid;
            end
            ST_CAPT: begin
                test_launch     = sel_fire && !last_q;
                misr_en         = 1'b1;
                misr_take_state = 1'b1;
            end
            ST_DONE: seq_done = 1'b1;
        endcase
    end

    AST_LAUNCH_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        test_launch |=> !test_launch); // R4
    AST_FAST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fast_clk_sel |=> !fast_clk_sel); // R3
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_clk_sel && test_cnt != CNT_MAX) |=> test_cnt == $past(test_cnt) + CNT_W'(1)); // R6
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> (seq_done && $stable(test_cnt))); // R7
endmodule

// File: rtl/fbt_ctrl.sv
module fbt_ctrl #(
    parameter int PI_W   = 4,
    parameter int PO_W   = 1,
    parameter int ST_W   = 3,
    parameter int MISR_W = 8,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_en,
    input  logic              seq_valid,
    input  logic              seq_last,
    input  logic [PI_W-1:0]   vec_in,
    input  logic [PO_W-1:0]   cut_out,
    input  logic [ST_W-1:0]   cut_state,
    output logic              test_launch,
    output logic              fast_clk_sel,
    output logic [MISR_W-1:0] misr_sig,
    output logic [CNT_W-1:0]  test_cnt,
    output logic              seq_done
);
    logic              sel_fire;
    logic              misr_en;
    logic              misr_take_state;
    logic [MISR_W-1:0] misr_data;

    fbt_sel_gate #(.PI_W(PI_W), .SEL_MASK(PI_W'(9))) u_gate (
        .sel_en   (sel_en),
        .seq_valid(seq_valid),
        .seq_last (seq_last),
        .vec_in   (vec_in),
        .sel_fire (sel_fire)
    );

    fbt_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .seq_valid      (seq_valid),
        .seq_last       (seq_last),
        .sel_fire       (sel_fire),
        .test_launch    (test_launch),
        .fast_clk_sel   (fast_clk_sel),
        .misr_en        (misr_en),
        .misr_take_state(misr_take_state),
        .seq_done       (seq_done),
        .test_cnt       (test_cnt)
    );

    assign misr_data = misr_take_state ? MISR_W'(cut_state) : MISR_W'(cut_out);

    fbt_misr #(.MISR_W(MISR_W), .TAP_MASK(MISR_W'(8'hB8))) u_misr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (misr_en),
        .cap_data (misr_data),
        .signature(misr_sig)
    );

    AST_NO_TEST_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_en |-> !test_launch); // R8
endmodule

// File: tb/sim_fbt_ctrl.sv
`timescale 1ns/1ps
module sim_fbt_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_en = 1'b0, seq_valid = 1'b0, seq_last = 1'b0;
    logic [3:0] vec_in = '0;
    logic [0:0] cut_out = '0;
    logic [2:0] cut_state = '0;
    logic       test_launch, fast_clk_sel, seq_done;
    logic [7:0] misr_sig, test_cnt;

    int checks = 0, errors = 0, cyc = 0, pat = 0;
    int m_st = 0;
    bit m_pend = 0;
    logic [7:0] m_sig = '0;
    int m_cnt = 0;
    logic [15:0] rng = 16'hACE1;
    bit finished = 0;

    always #4 clk = ~clk;

    fbt_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .sel_en(sel_en), .seq_valid(seq_valid),
        .seq_last(seq_last), .vec_in(vec_in), .cut_out(cut_out),
        .cut_state(cut_state), .test_launch(test_launch),
        .fast_clk_sel(fast_clk_sel), .misr_sig(misr_sig),
        .test_cnt(test_cnt), .seq_done(seq_done)
    );

    function automatic logic [7:0] misr_next(logic [7:0] s, logic [7:0] d);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]} ^ d;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sel_en = 0; seq_valid = 0; seq_last = 0; vec_in = '0;
        #1;
        chk("R1 sig in reset", int'(misr_sig), 0);
        chk("R1 cnt in reset", int'(test_cnt), 0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_st = 0; m_pend = 0; m_sig = '0; m_cnt = 0;
        #1;
        chk("R1 done", int'(seq_done), 0);
        chk("R1 fast", int'(fast_clk_sel), 0);
        chk("R1 launch", int'(test_launch), 0);
    endtask

    // one cycle: drive, check combinational outputs, advance model, check registers
    task automatic step(string tag, bit v, bit l, logic [3:0] vec, bit en);
        bit gate, e_launch, e_fast;
        @(negedge clk);
        pat++;
        seq_valid = v; seq_last = l; vec_in = vec; sel_en = en;
        cut_out = 1'(pat[0] ^ pat[3]);
        cut_state = 3'(pat) ^ 3'b101;
        #1;
        gate = en && v && !l && vec[0] && vec[3];
        e_launch = gate && (m_st == 0 || (m_st == 2 && !m_pend));
        e_fast = (m_st == 1) && v;
        chk({tag, " launch"}, int'(test_launch), int'(e_launch));
        chk({tag, " fast"}, int'(fast_clk_sel), int'(e_fast));
        if (e_fast) begin
            m_sig = misr_next(m_sig, {7'd0, cut_out});
            if (m_cnt < 255) m_cnt++;
        end
        if (m_st == 2) m_sig = misr_next(m_sig, {5'd0, cut_state});
        case (m_st)
            0: if (e_launch) m_st = 1; else if (v && l) m_st = 3;
            1: if (v) begin m_st = 2; m_pend = l; end
            2: if (m_pend) m_st = 3; else if (e_launch) m_st = 1;
               else if (v && l) m_st = 3; else m_st = 0;
            default: m_st = 3;
        endcase
        @(posedge clk);
        #1;
        chk("R5 signature", int'(misr_sig), int'(m_sig));
        chk("R6 count", int'(test_cnt), m_cnt);
        chk("R7 done", int'(seq_done), int'(m_st == 3));
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                checks++; errors++;
                $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
                summary();
            end
        end
    end

    initial begin : stim
        do_reset();
        // back-to-back firing and stalls
        step("R2", 1, 0, 4'b1001, 1);
        step("R4", 1, 0, 4'b1001, 1);
        step("R4", 1, 0, 4'b1001, 1);
        step("R9", 0, 0, 4'b1001, 1);
        step("R9", 0, 0, 4'b0000, 1);
        step("R3", 1, 0, 4'b0000, 1);
        step("R5", 1, 0, 4'b0110, 1);
        // sweep of every vector
        for (int i = 0; i < 16; i++) step("R2", 1, 0, 4'(i), 1);
        for (int i = 0; i < 16; i++) step("R2", 1, 0, 4'(15 - i), 1);
        // pseudo-random run with stalls
        for (int i = 0; i < 300; i++) begin
            rng = {rng[14:0], rng[15] ^ rng[13] ^ rng[12] ^ rng[10]};
            step("R3", rng[7:5] != 3'b000, 0, rng[3:0], 1);
        end
        step("R7", 1, 1, 4'b1001, 1);
        for (int i = 0; i < 4; i++) step("R7", 1, 0, 4'b1001, 1);

        // selection disabled
        do_reset();
        for (int i = 0; i < 40; i++) step("R8", 1, 0, 4'(i), 0);
        step("R8", 1, 1, 4'b1111, 0);

        // gate on the last vector is ignored
        do_reset();
        step("R7", 1, 0, 4'b0000, 1);
        step("R7", 1, 1, 4'b1001, 1);
        step("R7", 1, 0, 4'b1001, 1);

        // fast vector is the last one
        do_reset();
        step("R2", 1, 0, 4'b1111, 1);
        step("R7", 1, 1, 4'b1111, 1);
        step("R7", 1, 0, 4'b1111, 1);
        step("R7", 1, 0, 4'b1111, 1);

        // counter saturation
        do_reset();
        for (int i = 0; i < 540; i++) step("R6", 1, 0, 4'b1001, 1);
        chk("R6 saturated", int'(test_cnt), 255);

        summary();
    end
endmodule